// File: doc/BRIEF.md
# Buffered Event Pattern Transmitter

This block plays stored test events onto a word-wide output. A pattern RAM holds four event buffers. Each stored word carries a data field and four control flags. Software or a test harness loads the RAM through a plain write port. After that, each accept trigger names one buffer with a 2-bit index. A small state machine walks that buffer from its first location and pushes the words it finds into an output FIFO. The FIFO drains one entry per cycle onto the output pins.

Two kinds of control word are consumed internally and never reach the output. A latency word makes the walker pause for a programmable number of cycles. A gap word sets how many idle cycles follow each subsequent data word of the event. An empty-event word produces a single marker pulse and no data. The end-of-event flag closes the transfer. Triggers that arrive while a transfer runs wait in a four-deep trigger queue and are served in arrival order.

Top module: `evt_pattern_tx`

## Requirements
- R1: After reset, `out_valid`, `out_empty` and `out_eoe` are low, and nothing is emitted until a trigger is accepted.
- R2: While `wr_en` is high on a clock edge, the block stores `{wr_ctrl, wr_data}` at `wr_addr`. Bits [5:4] of `wr_addr` select the buffer and bits [3:0] select the word within it.
- R3: A trigger plays the buffer given by `trig_buf`, starting at word 0 and reading successive words.
- R4: The control flags are bit 0 end-of-event, bit 1 empty-event, bit 2 gap and bit 3 latency. When several flags are set, they are tested in this order: latency, gap, empty, data.
- R5: A data word appears for one cycle with `out_valid` high, its data on `out_data`, and `out_eoe` equal to its end flag. A word processed k cycles after the trigger edge appears k+1 cycles after it, and word 0 is processed 2 cycles after the trigger edge.
- R6: A latency word holding value L is not emitted. It takes 1+L cycles before the next word is processed.
- R7: A gap word holding value G is not emitted and takes one cycle. Every later data word of the same event that does not end the event is followed by G extra idle cycles. The gap value is 0 at the start of each event.
- R8: A word with its end flag set ends the event after that word is handled. A latency or gap word carrying the end flag ends the event with nothing emitted and no wait.
- R9: An empty-event word emits one `out_empty` pulse with `out_valid` low, and then ends the event. Its data bits are ignored.
- R10: An event with no end flag stops after the last word of its buffer.
- R11: Up to four pending triggers are queued and played in arrival order. A trigger that arrives while four are pending is discarded.
- R12: `out_valid` and `out_empty` are never high together, and `out_eoe` is high only with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern RAM write strobe |
| wr_addr | input | BAW+2 | Write address: buffer index in the top two bits, word index below |
| wr_data | input | DW | Data field to store |
| wr_ctrl | input | 4 | Control flags to store (end, empty, gap, latency) |
| trig | input | 1 | Accept trigger strobe |
| trig_buf | input | 2 | Buffer index for the trigger |
| out_valid | output | 1 | Data word present |
| out_data | output | DW | Emitted data word |
| out_eoe | output | 1 | Emitted word closes its event |
| out_empty | output | 1 | Empty-event marker pulse |

## Verification
If the wait counter or the gap register is wrong, the spacing between beats changes within the same event. A timing check against a cycle-exact model taken from the trigger edge catches this on the first affected word. If the flag decode is wrong, a latency or gap value leaks onto `out_data`, or the beat count of an event changes. If the trigger queue loses or repeats entries, or the buffer index is wrong, the content of the following event is wrong, which shows within one event time. Isolated events are compared cycle by cycle. Queued bursts are compared by content and order.

// File: rtl/evt_pattern_tx.sv
module evt_pattern_tx #(
  parameter int DW       = 16,
  parameter int BAW      = 4,
  parameter int TQ_DEPTH = 4,
  parameter int OF_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BAW+1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    wr_ctrl,
  input  logic          trig,
  input  logic [1:0]    trig_buf,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_eoe,
  output logic          out_empty
);
  localparam int AW    = BAW + 2;
  localparam int WORDS = 1 << AW;
  localparam int TPW   = (TQ_DEPTH > 1) ? $clog2(TQ_DEPTH) : 1;
  localparam int TCW   = $clog2(TQ_DEPTH + 1);
  localparam int OPW   = (OF_DEPTH > 1) ? $clog2(OF_DEPTH) : 1;
  localparam int OCW   = $clog2(OF_DEPTH + 1);
  localparam int EW    = DW + 2;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_WAIT = 2'd2} st_t;

  logic [DW+3:0] mem [WORDS];
  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= {wr_ctrl, wr_data};

  logic [1:0]     tq_q [TQ_DEPTH];
  logic [TPW-1:0] tq_wp, tq_rp;
  logic [TCW-1:0] tq_cnt;
  logic           tq_push, tq_pop;
  st_t            st;

  assign tq_push = trig && (tq_cnt != TCW'(TQ_DEPTH));
  assign tq_pop  = (st == S_IDLE) && (tq_cnt != '0);

  always_ff @(posedge clk)
    if (tq_push) tq_q[tq_wp] <= trig_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tq_wp  <= '0;
      tq_rp  <= '0;
      tq_cnt <= '0;
    end else begin
      if (tq_push) tq_wp <= (tq_wp == TPW'(TQ_DEPTH - 1)) ? '0 : tq_wp + 1'b1;
      if (tq_pop)  tq_rp <= (tq_rp == TPW'(TQ_DEPTH - 1)) ? '0 : tq_rp + 1'b1;
      if (tq_push && !tq_pop)      tq_cnt <= tq_cnt + 1'b1;
      else if (!tq_push && tq_pop) tq_cnt <= tq_cnt - 1'b1;
    end

  logic [BAW-1:0] addr;
  logic [1:0]     bsel;
  logic [DW-1:0]  gap, wcnt;
  logic [DW+3:0]  word;
  logic [DW-1:0]  wd;
  logic           w_end, w_emp, w_gap, w_lat, stop;

  assign word  = mem[{bsel, addr}];
  assign wd    = word[DW-1:0];
  assign w_end = word[DW];
  assign w_emp = word[DW+1];
  assign w_gap = word[DW+2];
  assign w_lat = word[DW+3];
  assign stop  = w_end || (addr == '1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      addr <= '0;
      bsel <= '0;
      gap  <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (tq_pop) begin
            bsel <= tq_q[tq_rp];
            addr <= '0;
            gap  <= '0;
            st   <= S_RUN;
          end
        S_RUN: begin
          addr <= addr + 1'b1;
          if (w_lat) begin
            if (stop) st <= S_IDLE;
            else if (wd != '0) begin
              wcnt <= wd;
              st   <= S_WAIT;
            end
          end else if (w_gap) begin
            gap <= wd;
            if (stop) st <= S_IDLE;
          end else if (w_emp) begin
            st <= S_IDLE;
          end else begin
            if (stop) st <= S_IDLE;
            else if (gap != '0) begin
              wcnt <= gap;
              st   <= S_WAIT;
            end
          end
        end
        S_WAIT:
          if (wcnt == DW'(1)) st <= S_RUN;
          else wcnt <= wcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  logic [EW-1:0]  of_q [OF_DEPTH];
  logic [OPW-1:0] of_wp, of_rp;
  logic [OCW-1:0] of_cnt;
  logic           of_push, of_pop;
  logic [EW-1:0]  of_din, of_head;

  assign of_push = (st == S_RUN) && !w_lat && !w_gap && (of_cnt != OCW'(OF_DEPTH));
  assign of_din  = w_emp ? {1'b1, 1'b0, {DW{1'b0}}} : {1'b0, w_end, wd};
  assign of_pop  = (of_cnt != '0);
  assign of_head = of_q[of_rp];

  always_ff @(posedge clk)
    if (of_push) of_q[of_wp] <= of_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      of_wp     <= '0;
      of_rp     <= '0;
      of_cnt    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eoe   <= 1'b0;
      out_empty <= 1'b0;
    end else begin
      if (of_push) of_wp <= (of_wp == OPW'(OF_DEPTH - 1)) ? '0 : of_wp + 1'b1;
      if (of_pop)  of_rp <= (of_rp == OPW'(OF_DEPTH - 1)) ? '0 : of_rp + 1'b1;
      if (of_push && !of_pop)      of_cnt <= of_cnt + 1'b1;
      else if (!of_push && of_pop) of_cnt <= of_cnt - 1'b1;
      out_valid <= of_pop && !of_head[DW+1];
      out_empty <= of_pop && of_head[DW+1];
      out_eoe   <= of_pop && of_head[DW];
      out_data  <= of_pop ? of_head[DW-1:0] : '0;
    end
endmodule

// File: rtl/evt_pattern_tx_chk.sv
module evt_pattern_tx_chk #(
  parameter int DW       = 16,
  parameter int TQ_DEPTH = 4,
  parameter int OF_DEPTH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          trig,
  input logic [$clog2(TQ_DEPTH+1)-1:0] tq_cnt,
  input logic                          tq_pop,
  input logic [1:0]                    st,
  input logic [DW-1:0]                 wcnt,
  input logic [$clog2(OF_DEPTH+1)-1:0] of_cnt,
  input logic                          out_valid,
  input logic                          out_eoe,
  input logic                          out_empty
);
  p_queue_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tq_cnt <= ($clog2(TQ_DEPTH+1))'(TQ_DEPTH));

  p_queue_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && tq_cnt == ($clog2(TQ_DEPTH+1))'(TQ_DEPTH) && !tq_pop) |=> (tq_cnt == $past(tq_cnt)));

  p_wait_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && wcnt != DW'(1)) |=> (st == 2'd2 && wcnt == $past(wcnt) - 1'b1));

  p_wait_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && wcnt == DW'(1)) |=> (st == 2'd1));

  p_beat_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_empty));

  p_eoe_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |-> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && of_cnt == '0) |=> (!out_valid && !out_empty));

  p_no_backlog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    of_cnt <= 1);
endmodule

bind evt_pattern_tx evt_pattern_tx_chk #(.DW(DW), .TQ_DEPTH(TQ_DEPTH), .OF_DEPTH(OF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .tq_cnt(tq_cnt), .tq_pop(tq_pop), .st(st),
  .wcnt(wcnt), .of_cnt(of_cnt), .out_valid(out_valid), .out_eoe(out_eoe), .out_empty(out_empty)
);

// File: tb/evt_pattern_tx_test.sv
`timescale 1ns/1ps
module evt_pattern_tx_test;
  localparam int BW = 16;
  localparam int MAXL = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] wr_ctrl = '0;
  logic trig = 1'b0;
  logic [1:0] trig_buf = '0;
  logic out_valid, out_eoe, out_empty;
  logic [15:0] out_data;

  evt_pattern_tx uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ctrl(wr_ctrl), .trig(trig), .trig_buf(trig_buf), .out_valid(out_valid), .out_data(out_data),
    .out_eoe(out_eoe), .out_empty(out_empty));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0, bad_beats = 0;
  logic [19:0] shadow [64];
  int lg_n = 0;
  int lg_cyc [MAXL];
  logic [15:0] lg_data [MAXL];
  bit lg_eoe [MAXL], lg_emp [MAXL];
  int ex_n = 0, ex_end = 0;
  int ex_off [MAXL];
  logic [15:0] ex_data [MAXL];
  bit ex_eoe [MAXL], ex_emp [MAXL];

  always @(negedge clk)
    if (rst_n) begin
      if ((out_valid && out_empty) || (out_eoe && !out_valid)) bad_beats++;
      if ((out_valid || out_empty) && lg_n < MAXL) begin
        lg_cyc[lg_n] = cyc; lg_data[lg_n] = out_data;
        lg_eoe[lg_n] = out_eoe; lg_emp[lg_n] = out_empty;
        lg_n++;
      end
    end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input int idx, input logic [3:0] c, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(idx); wr_ctrl = c; wr_data = d;
    shadow[idx] = {c, d};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ex_push(input int off, input logic [15:0] d, input bit e, input bit m);
    if (ex_n < MAXL) begin
      ex_off[ex_n] = off; ex_data[ex_n] = d; ex_eoe[ex_n] = e; ex_emp[ex_n] = m;
      ex_n++;
    end
  endtask

  // Cycle model of one event started from idle (R3..R10)
  task automatic model_event(input int b);
    int e = 2;
    int g = 0;
    for (int a = 0; a < BW; a++) begin
      logic [19:0] w = shadow[b*BW + a];
      bit last = (a == BW - 1);
      int v = int'(w[15:0]);
      if (w[19]) begin
        if (w[16] || last) break;
        e += 1 + v;
      end else if (w[18]) begin
        g = v;
        if (w[16] || last) break;
        e += 1;
      end else if (w[17]) begin
        ex_push(e + 1, 16'h0, 1'b0, 1'b1);
        break;
      end else begin
        ex_push(e + 1, w[15:0], w[16], 1'b0);
        if (w[16] || last) break;
        e += 1 + g;
      end
    end
    ex_end = e;
  endtask

  task automatic fire(input int b, output int t0);
    @(negedge clk);
    trig = 1'b1; trig_buf = 2'(b);
    @(negedge clk);
    t0 = cyc;
    trig = 1'b0;
  endtask

  task automatic compare(input string req, input bit timing, input int t0);
    chk(lg_n == ex_n, req, "beat count", lg_n, ex_n);
    for (int i = 0; i < lg_n && i < ex_n; i++) begin
      chk(lg_data[i] == ex_data[i], req, "data", int'(lg_data[i]), int'(ex_data[i]));
      chk(lg_eoe[i] == ex_eoe[i] && lg_emp[i] == ex_emp[i], req, "flags eoe*2+empty",
          lg_eoe[i]*2 + lg_emp[i], ex_eoe[i]*2 + ex_emp[i]);
      if (timing) chk(lg_cyc[i] - t0 == ex_off[i], req, "beat offset", lg_cyc[i] - t0, ex_off[i]);
    end
  endtask

  task automatic run_single(input int b, input string req);
    int t0;
    lg_n = 0; ex_n = 0;
    model_event(b);
    fire(b, t0);
    repeat (ex_end + 8) @(negedge clk);
    compare(req, 1'b1, t0);
  endtask

  task automatic fill_plain(input int b, input int base);
    for (int a = 0; a < BW; a++)
      wr_word(b*BW + a, (a == 1) ? 4'b0001 : 4'b0000, 16'(base + a));
  endtask

  task automatic fill_random();
    for (int i = 0; i < 64; i++) begin
      int r = int'($urandom % 100);
      logic [3:0] c;
      logic [15:0] d = 16'($urandom);
      if (r < 8)       begin c = 4'b1000; d = 16'($urandom % 6); end
      else if (r < 20) begin c = 4'b0100; d = 16'($urandom % 4); end
      else if (r < 24) c = 4'b0010;
      else if (r >= 88) c = 4'b0001;
      else c = 4'b0000;
      wr_word(i, c, d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R11 watchdog: actual cycle %0d expected completion", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_empty && !out_eoe, "R1", "outputs in reset", out_valid + out_empty + out_eoe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(lg_n == 0, "R1", "beats before trigger", lg_n, 0);

    for (int b = 0; b < 4; b++) fill_plain(b, b * 256);
    // R2 R3 R5: each buffer plays its own two words, first at offset 3
    for (int b = 0; b < 4; b++) run_single(b, "R2/R3/R5");

    // R6: latency 5 then a data word with end
    wr_word(16, 4'b1000, 16'd5);
    wr_word(17, 4'b0001, 16'hBEEF);
    run_single(1, "R6");
    // R6 zero latency costs one cycle
    wr_word(16, 4'b1000, 16'd0);
    run_single(1, "R6");

    // R7: gap 2, data, data, gap 0, data, data end
    wr_word(48, 4'b0100, 16'd2);
    wr_word(49, 4'b0000, 16'h1111);
    wr_word(50, 4'b0000, 16'h2222);
    wr_word(51, 4'b0100, 16'd0);
    wr_word(52, 4'b0000, 16'h3333);
    wr_word(53, 4'b0001, 16'h4444);
    run_single(3, "R7");

    // R9: empty word with nonzero data bits, later words not played
    wr_word(0, 4'b0010, 16'hABCD);
    run_single(0, "R9");

    // R8: gap word carrying end stops the event silently
    wr_word(0, 4'b0000, 16'h0A0A);
    wr_word(1, 4'b0101, 16'd3);
    wr_word(2, 4'b0001, 16'h0B0B);
    run_single(0, "R8");

    // R4: latency and gap set together, latency wins
    wr_word(0, 4'b1100, 16'd3);
    wr_word(1, 4'b0001, 16'h0C0C);
    run_single(0, "R4");

    // R10: no end flag, runs to the last word
    for (int a = 0; a < BW; a++) wr_word(32 + a, 4'b0000, 16'(16'h7000 + a));
    run_single(2, "R10");

    // R11: overflow of the trigger queue
    wr_word(16, 4'b1000, 16'd40);
    wr_word(17, 4'b0001, 16'h5151);
    wr_word(0, 4'b0001, 16'h6060);
    wr_word(48, 4'b0001, 16'h6363);
    wr_word(32, 4'b0001, 16'h6262);
    begin
      int order [6] = '{1, 0, 2, 3, 0, 2};
      lg_n = 0; ex_n = 0;
      for (int k = 0; k < 5; k++) model_event(order[k]);
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
        trig = 1'b1; trig_buf = 2'(order[k]);
        @(negedge clk);
      end
      trig = 1'b0;
      repeat (120) @(negedge clk);
      compare("R11", 1'b0, 0);
    end

    // Random isolated events, timed exactly
    for (int it = 0; it < 30; it++) begin
      fill_random();
      for (int k = 0; k < 2; k++) run_single(int'($urandom % 4), "R5/R6/R7 random");
    end

    // Random queued bursts, order and content
    for (int it = 0; it < 8; it++) begin
      int bs [3];
      int wt = 0;
      fill_random();
      lg_n = 0; ex_n = 0;
      for (int k = 0; k < 3; k++) begin
        bs[k] = int'($urandom % 4);
        model_event(bs[k]);
        wt += ex_end + 4;
      end
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        trig = 1'b1; trig_buf = 2'(bs[k]);
        @(negedge clk);
      end
      trig = 1'b0;
      repeat (wt + 10) @(negedge clk);
      compare("R11 random", 1'b0, 0);
    end

    chk(bad_beats == 0, "R12", "illegal output beats", bad_beats, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule